// File: doc/BRIEF.md
# Privilege-Masked Mask Register Bank

This block holds three 64-bit special-purpose registers used by a processor core for storage protection: an authority mask, a user override mask and a hypervisor override mask. Each request presents a register number, a read or write strobe, write data, and the core's current privilege state, given as a problem-state flag and a hypervisor flag. Reads return the stored value in the same cycle. Writes to the authority mask and to the user override mask are bit-merged: only the bit positions enabled by an override mask take the new data, and the rest keep their old value. The privilege level picks which override mask applies.

The authority mask is reachable through two register numbers that share one storage: a number that problem state may use and a privileged one. The block refuses any access that the current privilege level may not make, or that names an unmapped number. It flags a refused access on a fault output during the request cycle. A refused access changes no register and returns zero data. The core's decode and exception logic sit outside this block.

Top module: `amb_top`

## Requirements
- R1: A synchronous active-high reset clears all three registers to zero. After reset, every allowed read returns zero.
- R2: Register numbers 13 and 29 name the same authority-mask storage. A value written through either number reads back through both.
- R3: A write to the authority mask in problem state (problem flag 1) changes only the bits that are set in the user override mask. The result is (old & ~mask) | (data & mask).
- R4: A write to the authority mask in supervisor state (both flags 0) changes only the bits that are set in the hypervisor override mask.
- R5: A write to the authority mask in hypervisor state (problem flag 0, hypervisor flag 1) replaces the whole register.
- R6: A write to the user override mask (number 157) in supervisor state changes only the bits that are set in the hypervisor override mask. In hypervisor state it replaces the whole register.
- R7: In problem state, any access to number 29 or number 157 is refused.
- R8: The hypervisor override mask (number 349) may be read or written, unmasked, only in hypervisor state. An access to it at any other level is refused.
- R9: An access to any number other than 13, 29, 157 or 349 is refused.
- R10: When both the problem flag and the hypervisor flag are 1, the block treats the request as problem state.
- R11: A refused access drives fault to 1 in that cycle only, returns zero read data, and changes no register. When no request is valid, fault is 0 and read data is 0. A write request also returns zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_num | input | 10 | Register number |
| req_wdata | input | 64 | Write data |
| cpu_problem | input | 1 | Problem-state flag |
| cpu_hyper | input | 1 | Hypervisor flag |
| rd_data | output | 64 | Read data; zero unless an allowed read |
| fault | output | 1 | Request refused this cycle |

## Verification
The writes use override masks with alternating byte, half-word and word patterns. A merge that picks the wrong override mask, or that inverts the mask, therefore gives a visibly different result. The same data is written at each privilege level, so the user mask, the hypervisor mask and the unmasked path can each be told apart from the other two. Reads through both authority numbers confirm that the two numbers share storage. Refused requests follow each denied number and level pairing, and the read after each one shows that no register changed.

// File: rtl/amb_pkg.sv
package amb_pkg;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPER = 2'd1,
    LVL_HYP   = 2'd2
  } priv_t;

  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_AUTH_U = 3'd1,
    TGT_AUTH_P = 3'd2,
    TGT_UOVR   = 3'd3,
    TGT_HOVR   = 3'd4
  } tgt_t;

  typedef enum logic [1:0] {
    MSEL_FULL = 2'd0,
    MSEL_UOVR = 2'd1,
    MSEL_HOVR = 2'd2
  } msel_t;

  localparam int NREG     = 3;
  localparam int IDX_AUTH = 0;
  localparam int IDX_UOVR = 1;
  localparam int IDX_HOVR = 2;

  // Problem state wins whenever its flag is set.
  function automatic priv_t priv_of(input logic problem, input logic hyper);
    if (problem)    return LVL_USER;
    else if (hyper) return LVL_HYP;
    else            return LVL_SUPER;
  endfunction

endpackage

// File: rtl/amb_decode.sv
module amb_decode
  import amb_pkg::*;
#(
  parameter int NUM_W    = 10,
  parameter int N_AUTH_U = 13,
  parameter int N_AUTH_P = 29,
  parameter int N_UOVR   = 157,
  parameter int N_HOVR   = 349
) (
  input  logic [NUM_W-1:0] num,
  output tgt_t             tgt
);

  always_comb begin
    if      (num == NUM_W'(N_AUTH_U)) tgt = TGT_AUTH_U;
    else if (num == NUM_W'(N_AUTH_P)) tgt = TGT_AUTH_P;
    else if (num == NUM_W'(N_UOVR))   tgt = TGT_UOVR;
    else if (num == NUM_W'(N_HOVR))   tgt = TGT_HOVR;
    else                              tgt = TGT_NONE;
  end

endmodule

// File: rtl/amb_guard.sv
module amb_guard
  import amb_pkg::*;
(
  input  tgt_t       tgt,
  input  priv_t      lvl,
  output logic       allowed,
  output logic [1:0] reg_idx,
  output msel_t      msel
);

  always_comb begin
    allowed = 1'b0;
    reg_idx = 2'(IDX_AUTH);
    msel    = MSEL_FULL;
    unique case (tgt)
      TGT_AUTH_U: begin
        allowed = 1'b1;
        reg_idx = 2'(IDX_AUTH);
        msel    = (lvl == LVL_USER)  ? MSEL_UOVR :
                  (lvl == LVL_SUPER) ? MSEL_HOVR : MSEL_FULL;
      end
      TGT_AUTH_P: begin
        allowed = (lvl != LVL_USER);
        reg_idx = 2'(IDX_AUTH);
        msel    = (lvl == LVL_SUPER) ? MSEL_HOVR : MSEL_FULL;
      end
      TGT_UOVR: begin
        allowed = (lvl != LVL_USER);
        reg_idx = 2'(IDX_UOVR);
        msel    = (lvl == LVL_SUPER) ? MSEL_HOVR : MSEL_FULL;
      end
      TGT_HOVR: begin
        allowed = (lvl == LVL_HYP);
        reg_idx = 2'(IDX_HOVR);
        msel    = MSEL_FULL;
      end
      default: begin
        allowed = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/amb_merge_reg.sv
module amb_merge_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  function automatic logic [W-1:0] merge_bits(input logic [W-1:0] old_v,
                                               input logic [W-1:0] new_v,
                                               input logic [W-1:0] sel);
    return (old_v & ~sel) | (new_v & sel);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= merge_bits(q, wdata, mask);
  end

  // R11: without a write strobe the register holds its value.
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));

endmodule

// File: rtl/amb_top.sv
module amb_top
  import amb_pkg::*;
#(
  parameter int NUM_W    = 10,
  parameter int DATA_W   = 64,
  parameter int N_AUTH_U = 13,
  parameter int N_AUTH_P = 29,
  parameter int N_UOVR   = 157,
  parameter int N_HOVR   = 349
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [NUM_W-1:0]  req_num,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cpu_problem,
  input  logic              cpu_hyper,
  output logic [DATA_W-1:0] rd_data,
  output logic              fault
);

  localparam int IDX_W = $clog2(NREG);

  priv_t             lvl;
  tgt_t              tgt;
  logic              allowed;
  logic [1:0]        reg_idx;
  msel_t             msel;
  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] q [NREG];
  logic [DATA_W-1:0] auth_q, uovr_q, hovr_q;
  logic              wr_ok;

  assign lvl = priv_of(cpu_problem, cpu_hyper);

  amb_decode #(
    .NUM_W(NUM_W), .N_AUTH_U(N_AUTH_U), .N_AUTH_P(N_AUTH_P),
    .N_UOVR(N_UOVR), .N_HOVR(N_HOVR)
  ) i_decode (
    .num(req_num),
    .tgt(tgt)
  );

  amb_guard i_guard (
    .tgt    (tgt),
    .lvl    (lvl),
    .allowed(allowed),
    .reg_idx(reg_idx),
    .msel   (msel)
  );

  assign auth_q = q[IDX_AUTH];
  assign uovr_q = q[IDX_UOVR];
  assign hovr_q = q[IDX_HOVR];

  always_comb begin
    unique case (msel)
      MSEL_UOVR: wmask = uovr_q;
      MSEL_HOVR: wmask = hovr_q;
      default:   wmask = '1;
    endcase
  end

  assign fault = req_valid && !allowed;
  assign wr_ok = req_valid && req_write && allowed;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic we_g;
    assign we_g = wr_ok && (reg_idx == IDX_W'(g));
    amb_merge_reg #(.W(DATA_W)) i_reg (
      .clk  (clk),
      .rst  (rst),
      .we   (we_g),
      .mask (wmask),
      .wdata(req_wdata),
      .q    (q[g])
    );
  end

  always_comb begin
    rd_data = '0;
    if (req_valid && !req_write && allowed) begin
      unique case (reg_idx)
        2'(IDX_UOVR): rd_data = uovr_q;
        2'(IDX_HOVR): rd_data = hovr_q;
        default:      rd_data = auth_q;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic auth_wr;
  assign auth_wr = req_valid && req_write && !fault &&
                   (tgt == TGT_AUTH_U || tgt == TGT_AUTH_P);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (auth_q == '0 && uovr_q == '0 && hovr_q == '0));

  p_user_auth_merge_r3: assert property (@(posedge clk) disable iff (rst)
    (auth_wr && cpu_problem) |=>
      ((auth_q & ~$past(uovr_q)) == ($past(auth_q) & ~$past(uovr_q))) &&
      ((auth_q & $past(uovr_q)) == ($past(req_wdata) & $past(uovr_q))));

  p_super_auth_merge_r4: assert property (@(posedge clk) disable iff (rst)
    (auth_wr && !cpu_problem && !cpu_hyper) |=>
      ((auth_q & ~$past(hovr_q)) == ($past(auth_q) & ~$past(hovr_q))) &&
      ((auth_q & $past(hovr_q)) == ($past(req_wdata) & $past(hovr_q))));

  p_hyp_auth_full_r5: assert property (@(posedge clk) disable iff (rst)
    (auth_wr && !cpu_problem && cpu_hyper) |=> auth_q == $past(req_wdata));

  p_user_denied_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cpu_problem && (tgt == TGT_AUTH_P || tgt == TGT_UOVR)) |-> fault);

  p_hovr_hyp_only_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && tgt == TGT_HOVR && (cpu_problem || !cpu_hyper)) |-> fault);

  p_fault_no_change_r11: assert property (@(posedge clk) disable iff (rst)
    fault |=> ($stable(auth_q) && $stable(uovr_q) && $stable(hovr_q)));

  p_fault_zero_read_r11: assert property (@(posedge clk) disable iff (rst)
    fault |-> rd_data == '0);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (!fault && rd_data == '0));

endmodule

// File: tb/test_amb_top.sv
`timescale 1ns/1ps
module test_amb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [9:0]  req_num;
  logic [63:0] req_wdata;
  logic        cpu_problem, cpu_hyper;
  logic [63:0] rd_data;
  logic        fault;

  int n_checks = 0;
  int n_fail   = 0;
  logic [63:0] m_auth, m_uovr, m_hovr;

  always #2.5 clk = ~clk;

  amb_top i_amb_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_num(req_num), .req_wdata(req_wdata), .cpu_problem(cpu_problem),
    .cpu_hyper(cpu_hyper), .rd_data(rd_data), .fault(fault)
  );

  // {write, problem, hyper, number, data}
  localparam int NV = 20;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b1, 10'd349, 64'h00FF_00FF_00FF_00FF},
    {1'b0, 1'b0, 1'b1, 10'd349, 64'h0},
    {1'b1, 1'b0, 1'b1, 10'd157, 64'hFFFF_FFFF_0000_0000},
    {1'b1, 1'b0, 1'b0, 10'd157, 64'h0123_4567_89AB_CDEF},
    {1'b0, 1'b0, 1'b0, 10'd157, 64'h0},
    {1'b1, 1'b0, 1'b1, 10'd29,  64'hA5A5_A5A5_A5A5_A5A5},
    {1'b0, 1'b1, 1'b0, 10'd13,  64'h0},
    {1'b1, 1'b1, 1'b0, 10'd13,  64'h0},
    {1'b0, 1'b0, 1'b0, 10'd29,  64'h0},
    {1'b1, 1'b0, 1'b0, 10'd29,  64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 1'b0, 1'b1, 10'd13,  64'h0},
    {1'b1, 1'b1, 1'b0, 10'd29,  64'h1111_2222_3333_4444},
    {1'b0, 1'b1, 1'b0, 10'd157, 64'h0},
    {1'b1, 1'b0, 1'b0, 10'd349, 64'hDEAD_BEEF_DEAD_BEEF},
    {1'b0, 1'b1, 1'b0, 10'd349, 64'h0},
    {1'b1, 1'b1, 1'b1, 10'd13,  64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 1'b1, 1'b1, 10'd349, 64'h0},
    {1'b1, 1'b0, 1'b1, 10'd100, 64'h5555_5555_5555_5555},
    {1'b0, 1'b0, 1'b0, 10'd13,  64'h0},
    {1'b0, 1'b0, 1'b0, 10'd200, 64'h0}
  };

  // Independent model: level rules written as a permission table per number.
  function automatic bit exp_ok(bit pr, bit hv, int num);
    bit user = pr;
    bit hyp  = !pr && hv;
    case (num)
      13:      return 1;
      29, 157: return !user;
      349:     return hyp;
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] exp_mask(bit pr, bit hv, int num);
    if (num == 349 || (!pr && hv)) return '1;
    if (pr && num == 13)           return m_uovr;
    return m_hovr;
  endfunction

  function automatic logic [63:0] exp_read(int num);
    if (num == 157) return m_uovr;
    if (num == 349) return m_hovr;
    return m_auth;
  endfunction

  function automatic logic [63:0] bitwise_merge(logic [63:0] o, logic [63:0] d, logic [63:0] m);
    logic [63:0] r;
    for (int b = 0; b < 64; b++) r[b] = m[b] ? d[b] : o[b];
    return r;
  endfunction

  function automatic string tag_of(bit wr, bit pr, bit hv, int num);
    bit ok = exp_ok(pr, hv, num);
    if (!(num == 13 || num == 29 || num == 157 || num == 349)) return "R9";
    if (pr && hv)    return "R10";
    if (num == 349)  return "R8";
    if (!ok)         return "R7";
    if (num == 157)  return "R6";
    if (!wr)         return "R2";
    if (pr)          return "R3";
    if (hv)          return "R5";
    return "R4";
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Drive at negedge, check before the next posedge, model updates with the edge.
  task automatic do_req(bit wr, bit pr, bit hv, logic [9:0] num, logic [63:0] d, string tag);
    bit ok;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; cpu_problem = pr; cpu_hyper = hv;
    req_num = num; req_wdata = d;
    ok = exp_ok(pr, hv, int'(num));
    #1;
    check(tag, "fault", {63'b0, fault}, {63'b0, !ok});
    check(tag, "rd_data", rd_data, (ok && !wr) ? exp_read(int'(num)) : 64'h0);
    if (ok && wr) begin
      logic [63:0] m = exp_mask(pr, hv, int'(num));
      case (int'(num))
        157:     m_uovr = bitwise_merge(m_uovr, d, m);
        349:     m_hovr = bitwise_merge(m_hovr, d, m);
        default: m_auth = bitwise_merge(m_auth, d, m);
      endcase
    end
    @(posedge clk);
  endtask

  task automatic idle_check();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b1; req_num = 10'd13; req_wdata = '1;
    cpu_problem = 1'b0; cpu_hyper = 1'b1;
    #1;
    check("R11", "idle fault", {63'b0, fault}, 64'h0);
    check("R11", "idle rd_data", rd_data, 64'h0);
    @(posedge clk);
  endtask

  initial begin : watchdog
    #100000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_num = '0;
    req_wdata = '0; cpu_problem = 1'b0; cpu_hyper = 1'b0;
    m_auth = '0; m_uovr = '0; m_hovr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state through each number
    do_req(0, 0, 1, 10'd13,  '0, "R1");
    do_req(0, 0, 1, 10'd157, '0, "R1");
    do_req(0, 0, 1, 10'd349, '0, "R1");

    for (int i = 0; i < NV; i++) begin
      logic [76:0] v = VEC[i];
      do_req(v[76], v[75], v[74], v[73:64], v[63:0],
             tag_of(v[76], v[75], v[74], int'(v[73:64])));
    end

    // R11: idle request and writes return zero data
    idle_check();
    do_req(1, 0, 1, 10'd13, 64'hCAFE_F00D_0000_1234, "R5");
    do_req(0, 1, 0, 10'd13, '0, "R2");
    do_req(1, 0, 0, 10'd200, '1, "R9");
    do_req(0, 0, 0, 10'd29, '0, "R11");

    // R1: mid-run reset clears everything
    @(negedge clk) rst = 1'b1; req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk) rst = 1'b0;
    m_auth = '0; m_uovr = '0; m_hovr = '0;
    do_req(0, 0, 1, 10'd29,  '0, "R1");
    do_req(0, 0, 1, 10'd157, '0, "R1");
    do_req(0, 0, 1, 10'd349, '0, "R1");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule